// File: doc/BRIEF.md
# Byte-Fed Selectable-Width CRC Unit

This block is a register-mapped CRC accelerator for a small microcontroller bus. Software writes data one byte at a time into a feed register. Each write folds that byte into a running checksum, which is either 16 or 32 bits wide. A control register selects the width, picks an all-zeros or all-ones starting value and triggers initialisation. The same control write also positions a byte pointer.

The checksum register is reached one byte at a time through a data port. The pointer chooses which of the four result bytes the port shows. Every read or write of the port moves the pointer on by one. Writing the port overwrites the selected result byte, so software can resume a checksum that it saved earlier. A separate mirror register returns the last byte written to it with its bit order reversed.

The bus is a plain strobe interface. A write or a read strobe goes with a 2-bit register address: 0 is control, 1 is feed, 2 is the result port and 3 is the mirror. Read data is combinational from the address.

Top module: `crc_unit`

## Requirements
- R1: After reset, the control register reads 0x00, the pointer is 0 and all four result bytes read 0x00.
- R2: In 16-bit mode (control bit 0 = 0), each fed byte is XORed into bits 15:8 of the checksum. Eight MSB-first shift steps with polynomial 0x1021 follow. Starting from zero, feeding the ASCII string "123456789" gives 0x31C3. Result byte 0 is bits 7:0.
- R3: In 16-bit mode, starting from all ones, the same string gives 0x29B1.
- R4: In 32-bit mode (control bit 0 = 1), the same procedure acts on bits 31:24 with polynomial 0x04C11DB7. Starting from all ones, the string gives 0x0376E6E7.
- R5: A control write with bit 2 set loads the checksum in the next cycle. The value is zero when bit 1 is 0. When bit 1 is 1, the value is all ones: 0xFFFFFFFF in 32-bit mode and 0x0000FFFF in 16-bit mode. The width comes from bit 0 of the same write.
- R6: Bits 5:4 of a control write set the pointer. Each read or write of the result port advances it by one, and it wraps from 3 to 0.
- R7: In 16-bit mode, result bytes 2 and 3 read as 0x00.
- R8: A write to the result port replaces the byte the pointer selects, and later bytes are folded into the replaced value.
- R9: Byte writes on consecutive cycles are each folded in. Each byte sees the checksum left by the byte before it.
- R10: Reading the mirror register returns the last byte written there with bit i moved to bit 7-i.
- R11: The control register reads back bit 0 (width), bit 1 (initial-value select) and the pointer in bits 5:4. Bit 2 and the other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe (advances the pointer on port reads) |
| addr_i | input | 2 | Register address: 0 control, 1 feed, 2 result port, 3 mirror |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |

## Verification
The assertions assume at most one register access per cycle, so feed, control and port writes never collide. They also assume that read and write strobes are never both asserted on the result port in the same cycle. The stimulus holds every strobe for exactly one cycle and issues one access at a time. This keeps the pointer stepping at one position per access. The inputs stay low throughout reset, so properties that look one cycle back only ever see reset values or legal accesses.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int BYTE_W  = 8;
  localparam int N_BYTES = 4;
  localparam int CRC_W   = BYTE_W * N_BYTES;
  localparam int PTR_W   = $clog2(N_BYTES);
  localparam int NARROW_W = 16;
  localparam int NARROW_BYTES = NARROW_W / BYTE_W;

  localparam logic [NARROW_W-1:0] POLY_NARROW = 16'h1021;
  localparam logic [CRC_W-1:0]    POLY_WIDE   = 32'h04C11DB7;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_FEED   = 2'd1,
    REG_PORT   = 2'd2,
    REG_MIRROR = 2'd3
  } reg_addr_e;

  // control field positions
  localparam int CTL_WIDE  = 0;
  localparam int CTL_ONES  = 1;
  localparam int CTL_INIT  = 2;
  localparam int CTL_PTR   = 4;

  function automatic logic [CRC_W-1:0] crc_fold(input logic [CRC_W-1:0] c,
                                                input logic [BYTE_W-1:0] d,
                                                input logic wide);
    logic [CRC_W-1:0]    w;
    logic [NARROW_W-1:0] n;
    w = c ^ {d, {(CRC_W-BYTE_W){1'b0}}};
    n = c[NARROW_W-1:0] ^ {d, {(NARROW_W-BYTE_W){1'b0}}};
    for (int i = 0; i < BYTE_W; i++) begin
      w = w[CRC_W-1]    ? ((w << 1) ^ POLY_WIDE)   : (w << 1);
      n = n[NARROW_W-1] ? ((n << 1) ^ POLY_NARROW) : (n << 1);
    end
    return wide ? w : {{(CRC_W-NARROW_W){1'b0}}, n};
  endfunction
endpackage

// File: rtl/crc_engine.sv
module crc_engine
  import crc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_i,
  input  logic              init_i,
  input  logic              init_wide_i,
  input  logic              init_ones_i,
  input  logic              feed_i,
  input  logic [BYTE_W-1:0] feed_byte_i,
  input  logic              preset_i,
  input  logic [PTR_W-1:0]  preset_idx_i,
  input  logic [BYTE_W-1:0] preset_byte_i,
  output logic [CRC_W-1:0]  crc_o
);
  localparam logic [CRC_W-1:0] ONES_NARROW = {{(CRC_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [CRC_W-1:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (init_i)
      crc_d = init_ones_i ? (init_wide_i ? {CRC_W{1'b1}} : ONES_NARROW) : '0;
    else if (feed_i)
      crc_d = crc_fold(crc_q, feed_byte_i, wide_i);
    else if (preset_i)
      crc_d[preset_idx_i*BYTE_W +: BYTE_W] = preset_byte_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) crc_q <= '0;
    else         crc_q <= crc_d;
  end

  assign crc_o = crc_q;

  assert_init_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> crc_o == ($past(init_ones_i)
                         ? ($past(init_wide_i) ? {CRC_W{1'b1}} : ONES_NARROW) : '0));

  assert_narrow_top_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (feed_i && !init_i && !wide_i) |=> crc_o[CRC_W-1:NARROW_W] == '0);

  assert_hold_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && !feed_i && !preset_i) |=> $stable(crc_o));
endmodule

// File: rtl/crc_result_port.sv
module crc_result_port
  import crc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_i,
  input  logic              set_i,
  input  logic [PTR_W-1:0]  set_val_i,
  input  logic              step_i,
  input  logic [CRC_W-1:0]  crc_i,
  output logic [PTR_W-1:0]  ptr_o,
  output logic [BYTE_W-1:0] byte_o
);
  logic [PTR_W-1:0]  ptr_q;
  logic [BYTE_W-1:0] lane [N_BYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (set_i)  ptr_q <= set_val_i;
    else if (step_i) ptr_q <= ptr_q + 1'b1;
  end

  for (genvar g = 0; g < N_BYTES; g++) begin : g_lane
    if (g < NARROW_BYTES) begin : g_low
      assign lane[g] = crc_i[g*BYTE_W +: BYTE_W];
    end else begin : g_high
      assign lane[g] = wide_i ? crc_i[g*BYTE_W +: BYTE_W] : '0;
    end
  end

  assign byte_o = lane[ptr_q];
  assign ptr_o  = ptr_q;

  assert_ptr_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !set_i) |=> ptr_o == PTR_W'($past(ptr_o) + 1'b1));

  assert_high_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wide_i && ptr_o >= PTR_W'(NARROW_BYTES)) |-> byte_o == '0);
endmodule

// File: rtl/bit_mirror.sv
module bit_mirror
  import crc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [BYTE_W-1:0] q_o
);
  logic [BYTE_W-1:0] q;
  logic [BYTE_W-1:0] rev;

  for (genvar g = 0; g < BYTE_W; g++) begin : g_rev
    assign rev[g] = data_i[BYTE_W-1-g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (wr_i) q <= rev;
  end

  assign q_o = q;

  assert_mirror_ends_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (q_o[0] == $past(data_i[BYTE_W-1])) && (q_o[BYTE_W-1] == $past(data_i[0])));
endmodule

// File: rtl/crc_unit.sv
module crc_unit
  import crc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [1:0]        addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o
);
  logic wr_ctrl, wr_feed, wr_port, wr_mirror, port_step;
  logic wide_q, ones_q;
  logic [CRC_W-1:0]  crc;
  logic [PTR_W-1:0]  ptr;
  logic [BYTE_W-1:0] port_byte, mirror_byte;
  logic              ctrl_unused;

  assign wr_ctrl   = wr_en_i && (addr_i == REG_CTRL);
  assign wr_feed   = wr_en_i && (addr_i == REG_FEED);
  assign wr_port   = wr_en_i && (addr_i == REG_PORT);
  assign wr_mirror = wr_en_i && (addr_i == REG_MIRROR);
  assign port_step = (wr_en_i || rd_en_i) && (addr_i == REG_PORT);
  assign ctrl_unused = ^{wdata_i[BYTE_W-1:CTL_PTR+PTR_W], wdata_i[CTL_PTR-1:CTL_INIT+1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wide_q <= 1'b0;
      ones_q <= 1'b0;
    end else if (wr_ctrl) begin
      wide_q <= wdata_i[CTL_WIDE];
      ones_q <= wdata_i[CTL_ONES];
    end
  end

  crc_engine u_engine (
    .clk_i,
    .rst_ni,
    .wide_i       (wide_q),
    .init_i       (wr_ctrl && wdata_i[CTL_INIT]),
    .init_wide_i  (wdata_i[CTL_WIDE]),
    .init_ones_i  (wdata_i[CTL_ONES]),
    .feed_i       (wr_feed),
    .feed_byte_i  (wdata_i),
    .preset_i     (wr_port),
    .preset_idx_i (ptr),
    .preset_byte_i(wdata_i),
    .crc_o        (crc)
  );

  crc_result_port u_port (
    .clk_i,
    .rst_ni,
    .wide_i   (wide_q),
    .set_i    (wr_ctrl),
    .set_val_i(wdata_i[CTL_PTR +: PTR_W]),
    .step_i   (port_step),
    .crc_i    (crc),
    .ptr_o    (ptr),
    .byte_o   (port_byte)
  );

  bit_mirror u_mirror (
    .clk_i,
    .rst_ni,
    .wr_i  (wr_mirror),
    .data_i(wdata_i),
    .q_o   (mirror_byte)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_CTRL: begin
        rdata_o[CTL_WIDE] = wide_q;
        rdata_o[CTL_ONES] = ones_q;
        rdata_o[CTL_PTR +: PTR_W] = ptr;
      end
      REG_FEED:   rdata_o = '0;
      REG_PORT:   rdata_o = port_byte;
      REG_MIRROR: rdata_o = mirror_byte;
      default:    rdata_o = '0;
    endcase
  end

  assert_ctrl_init_bit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == REG_CTRL) |-> rdata_o[CTL_INIT] == 1'b0);

  assert_one_port_access_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_port && rd_en_i));
endmodule

// File: tb/sim_crc_unit.sv
module sim_crc_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int  total = 0, bad = 0;
  bit  done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  crc_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  // bit-serial reference model
  function automatic logic [31:0] ref_byte(logic [31:0] c, logic [7:0] d, bit wide);
    int top;
    logic [31:0] poly;
    logic fb;
    top  = wide ? 31 : 15;
    poly = wide ? 32'h04C11DB7 : 32'h00001021;
    for (int i = 7; i >= 0; i--) begin
      fb = c[top] ^ d[i];
      c  = c << 1;
      if (!wide) c[31:16] = '0;
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_en = 1'b1; addr = a;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  // monitor: compares each read against the scoreboard
  always @(negedge clk) begin
    if (rd_en && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (rdata !== e) begin
        bad++;
        $display("FAIL %s actual=%02h expected=%02h", t, rdata, e);
      end
    end
  end

  task automatic feed_str(output logic [31:0] m, input logic [31:0] start, input bit wide);
    string s;
    s = "123456789";
    m = start;
    for (int i = 0; i < s.len(); i++) begin
      wr(2'd1, s[i]);
      m = ref_byte(m, s[i], wide);
    end
  endtask

  task automatic rd_word(input logic [31:0] v, input string tag);
    for (int i = 0; i < 4; i++) rd(2'd2, v[i*8 +: 8], tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] m;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    rd(2'd0, 8'h00, "R1 ctrl");
    rd_word(32'h0, "R1 result");

    // R2 narrow from zero, R7 upper bytes, R6 wrap
    wr(2'd0, 8'h04);
    feed_str(m, 32'h0, 1'b0);
    wr(2'd0, 8'h00);
    rd(2'd2, 8'hC3, "R2 byte0");
    rd(2'd2, 8'h31, "R2 byte1");
    rd(2'd2, 8'h00, "R7 byte2");
    rd(2'd2, 8'h00, "R7 byte3");
    rd(2'd2, m[7:0], "R6 wrap to byte0");

    // R3 narrow from ones, R11 readback
    wr(2'd0, 8'h06);
    feed_str(m, 32'h0000FFFF, 1'b0);
    wr(2'd0, 8'h02);
    rd(2'd2, 8'hB1, "R3 byte0");
    rd(2'd2, 8'h29, "R3 byte1");
    rd(2'd0, 8'h22, "R11 ctrl readback");

    // R4 wide from ones
    wr(2'd0, 8'h07);
    feed_str(m, 32'hFFFFFFFF, 1'b1);
    wr(2'd0, 8'h03);
    rd_word(32'h0376E6E7, "R4 result");
    wr(2'd0, 8'h03);
    rd_word(m, "R4 model");

    // R5 init values
    wr(2'd0, 8'h05);
    wr(2'd0, 8'h01);
    rd_word(32'h0, "R5 wide zero");
    wr(2'd0, 8'h07);
    wr(2'd0, 8'h03);
    rd_word(32'hFFFFFFFF, "R5 wide ones");
    wr(2'd0, 8'h06);
    wr(2'd0, 8'h02);
    rd_word(32'h0000FFFF, "R5 narrow ones");

    // R8 preset through the port, then fold
    wr(2'd0, 8'h04);
    wr(2'd2, 8'h34);
    wr(2'd2, 8'h12);
    rd(2'd0, 8'h20, "R6 ptr after two writes");
    wr(2'd0, 8'h00);
    rd(2'd2, 8'h34, "R8 preset byte0");
    rd(2'd2, 8'h12, "R8 preset byte1");
    wr(2'd1, 8'hAB);
    m = ref_byte(32'h1234, 8'hAB, 1'b0);
    wr(2'd0, 8'h00);
    rd(2'd2, m[7:0], "R8 fold byte0");
    rd(2'd2, m[15:8], "R8 fold byte1");

    // R6 pointer set to 3 then wrap, wide mode
    wr(2'd0, 8'h35);
    wr(2'd2, 8'h9C);
    rd(2'd2, 8'h00, "R6 wrap after write at 3");
    wr(2'd0, 8'h31);
    rd(2'd2, 8'h9C, "R8 wide byte3 preset");

    // R9 back-to-back wide feed
    wr(2'd0, 8'h05);
    m = 32'h0;
    for (int i = 0; i < 16; i++) begin
      logic [7:0] b;
      b = 8'(i * 37 + 5);
      wr(2'd1, b);
      m = ref_byte(m, b, 1'b1);
    end
    wr(2'd0, 8'h01);
    rd_word(m, "R9 burst");

    // R10 mirror
    wr(2'd3, 8'h01);
    rd(2'd3, 8'h80, "R10 01");
    wr(2'd3, 8'h12);
    rd(2'd3, 8'h48, "R10 12");
    wr(2'd3, 8'hF0);
    rd(2'd3, 8'h0F, "R10 F0");
    rd(2'd3, 8'h0F, "R10 hold");

    @(posedge clk); #1;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule